// File: doc/BRIEF.md
# SRAM Parity Error Collector

This block gathers single-cycle parity-error indications from seven on-chip memory regions and records each one in a sticky status flag. Software gives each region its own enable bit. An interrupt request is raised as a level whenever a recorded flag has its enable set. This request is meant for the non-maskable input of the interrupt controller.

A global parity-available bit starts at 1 after power-on reset. Software can clear it by writing the one-shot disable. Once it is cleared, no register write can bring it back; only power-on reset restores it. While it is 0, incoming error pulses are ignored and the interrupt request is held low.

The block has two resets. Power-on reset clears everything and sets the available bit. Warm reset clears only the flags and enables. Software reads the status register to collect the flags, and that read clears them. An error that arrives in the same cycle as the read is kept for the next read.

Top module: `sram_parity_collector`

## Requirements
- R1: After power-on reset, the enable register reads 0, the status register reads 0, the control register bit 0 (available) reads 1, and `irq_o` is 0.
- R2: With available at 1, an error pulse on `par_err_i[i]` sets status bit i at the next clock edge, and the bit stays set until a status read.
- R3: A read of the status register (address 1) returns the flags in bits 6:0 and clears them. A second read with no new errors returns 0.
- R4: If `par_err_i[i]` is high in the same cycle as a status read, that read returns the old flags, and bit i is set afterwards.
- R5: `irq_o` is 1 exactly when available is 1 and at least one region has both its flag and its enable bit set.
- R6: The enable register (address 0) stores `bus_wdata_i[6:0]` on a write. It reads back in bits 6:0, and `bus_rdata_o` bits above 6 read 0.
- R7: Writing the control register (address 2) with bit 0 = 1 clears available at the next edge. Writing it with bit 0 = 0 leaves available unchanged.
- R8: Once available is 0, it stays 0 through any register write and through warm reset. Only power-on reset sets it back to 1.
- R9: While available is 0, error pulses set no flag and `irq_o` stays 0. Flags recorded earlier remain readable.
- R10: Warm reset clears all enable bits and status flags and does not change available.
- R11: Error pulses on several regions in the same cycle each set their own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous; clears flags and enables only |
| par_err_i | input | NREG (7) | Parity error pulses, one per memory region |
| bus_valid_i | input | 1 | Register access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 enable, 1 status, 2 control |
| bus_wdata_i | input | NREG (7) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational for the addressed register |
| irq_o | output | 1 | Non-maskable interrupt request level |

## Verification
The tests drive single-region pulses, multi-region pulses, and pulses that land in the same cycle as a status read. Comparing these shows whether flags are recorded per region and kept sticky, and whether the clear-on-read can drop an event that arrives during the read. The interrupt is checked with a flag set on an enabled region and with a flag set on a disabled one, so gating by the wrong bit shows up. Disable writes with bit 0 at 0 and at 1 are issued before and after warm and power-on resets. They separate the one-shot behaviour of the available bit from ordinary register bits, and show that ignored errors leave no trace.

// File: rtl/parity_collector_pkg.sv
package parity_collector_pkg;

  localparam int NREG_DEFAULT = 7;
  localparam int DW_DEFAULT   = 32;
  localparam int AW           = 2;

  typedef enum logic [AW-1:0] {
    RA_ENABLE  = 2'd0,
    RA_STATUS  = 2'd1,
    RA_CONTROL = 2'd2
  } reg_addr_e;

  // Next value of one sticky flag: a read clears it, and a qualified error
  // sets it. Set wins over clear so a coincident event is not lost.
  function automatic logic flag_next(input logic cur, input logic rd_clr,
                                     input logic err, input logic avail);
    return (cur & ~rd_clr) | (err & avail);
  endfunction

  function automatic logic is_access(input logic valid, input logic wr,
                                     input logic want_wr,
                                     input logic [AW-1:0] addr,
                                     input reg_addr_e target);
    return valid && (wr == want_wr) && (addr == target);
  endfunction

endpackage

// File: rtl/pc_avail_latch.sv
module pc_avail_latch (
  input  logic clk,
  input  logic por_n,
  input  logic kill_ev,
  output logic avail_o
);
  logic avail_q;

  // Only power-on reset can set the bit; no functional path raises it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       avail_q <= 1'b1;
    else if (kill_ev) avail_q <= 1'b0;
  end

  assign avail_o = avail_q;
endmodule

// File: rtl/pc_flag_bank.sv
module pc_flag_bank #(
  parameter int NREG = parity_collector_pkg::NREG_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            avail_i,
  input  logic            rd_clr_i,
  input  logic [NREG-1:0] err_i,
  output logic [NREG-1:0] flags_o,
  output logic [NREG-1:0] set_ev_o
);
  import parity_collector_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= flag_next(q, rd_clr_i, err_i[g], avail_i);
    end
    assign flags_o[g]  = q;
    assign set_ev_o[g] = err_i[g] & avail_i;
  end
endmodule

// File: rtl/pc_reg_if.sv
module pc_reg_if #(
  parameter int NREG = parity_collector_pkg::NREG_DEFAULT,
  parameter int DW   = parity_collector_pkg::DW_DEFAULT
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 valid_i,
  input  logic                                 write_i,
  input  logic [parity_collector_pkg::AW-1:0]  addr_i,
  input  logic [NREG-1:0]                      wdata_i,
  input  logic [NREG-1:0]                      flags_i,
  input  logic                                 avail_i,
  output logic [NREG-1:0]                      en_o,
  output logic                                 rd_status_ev_o,
  output logic                                 kill_ev_o,
  output logic [DW-1:0]                        rdata_o
);
  import parity_collector_pkg::*;

  localparam int PAD = DW - NREG;

  logic            wr_en_ev;
  logic [NREG-1:0] en_q;

  assign wr_en_ev       = is_access(valid_i, write_i, 1'b1, addr_i, RA_ENABLE);
  assign rd_status_ev_o = is_access(valid_i, write_i, 1'b0, addr_i, RA_STATUS);
  assign kill_ev_o      = is_access(valid_i, write_i, 1'b1, addr_i, RA_CONTROL)
                          && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (wr_en_ev) en_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (valid_i && !write_i) begin
      case (addr_i)
        RA_ENABLE:  rdata_o = {{PAD{1'b0}}, en_q};
        RA_STATUS:  rdata_o = {{PAD{1'b0}}, flags_i};
        RA_CONTROL: rdata_o = {{(DW-1){1'b0}}, avail_i};
        default:    rdata_o = '0;
      endcase
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/sram_parity_collector.sv
module sram_parity_collector #(
  parameter int NREG = parity_collector_pkg::NREG_DEFAULT,
  parameter int DW   = parity_collector_pkg::DW_DEFAULT
) (
  input  logic                                clk,
  input  logic                                por_n,
  input  logic                                warm_rst_n,
  input  logic [NREG-1:0]                     par_err_i,
  input  logic                                bus_valid_i,
  input  logic                                bus_write_i,
  input  logic [parity_collector_pkg::AW-1:0] bus_addr_i,
  input  logic [NREG-1:0]                     bus_wdata_i,
  output logic [DW-1:0]                       bus_rdata_o,
  output logic                                irq_o
);
  // Named internal events, visible to the bound checker.
  logic            rst_any_n;
  logic            avail_q;
  logic            kill_ev;
  logic            rd_status_ev;
  logic [NREG-1:0] flags;
  logic [NREG-1:0] en;
  logic [NREG-1:0] set_ev;
  logic            set_any;

  assign rst_any_n = por_n & warm_rst_n;

  pc_avail_latch u_avail (
    .clk     (clk),
    .por_n   (por_n),
    .kill_ev (kill_ev),
    .avail_o (avail_q)
  );

  pc_flag_bank #(.NREG(NREG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_any_n),
    .avail_i  (avail_q),
    .rd_clr_i (rd_status_ev),
    .err_i    (par_err_i),
    .flags_o  (flags),
    .set_ev_o (set_ev)
  );

  pc_reg_if #(.NREG(NREG), .DW(DW)) u_regs (
    .clk            (clk),
    .rst_n          (rst_any_n),
    .valid_i        (bus_valid_i),
    .write_i        (bus_write_i),
    .addr_i         (bus_addr_i),
    .wdata_i        (bus_wdata_i),
    .flags_i        (flags),
    .avail_i        (avail_q),
    .en_o           (en),
    .rd_status_ev_o (rd_status_ev),
    .kill_ev_o      (kill_ev),
    .rdata_o        (bus_rdata_o)
  );

  assign set_any = |set_ev;
  assign irq_o   = avail_q & (|(flags & en));
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int NREG = 7
) (
  input logic            clk,
  input logic            por_n,
  input logic            rst_n,
  input logic            avail,
  input logic            kill_ev,
  input logic            rd_ev,
  input logic            set_any,
  input logic [NREG-1:0] err,
  input logic [NREG-1:0] flags,
  input logic [NREG-1:0] en,
  input logic            irq
);
  p_kill_r7: assert property (@(posedge clk) disable iff (!por_n)
    kill_ev |=> !avail);

  p_no_revive_r8: assert property (@(posedge clk) disable iff (!por_n)
    !avail |=> !avail);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> ((flags & $past(flags)) == $past(flags)));

  p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && set_any) |=> ((flags & $past(err)) == $past(err)));

  p_read_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && avail) |=> (flags == $past(err)));

  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !avail) |=> (flags == '0));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && !rd_ev) |=> (flags == $past(flags)));

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (avail && ((flags & en) != '0)));

  p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && ((flags & en) != '0)) |-> irq);

  p_warm_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> (flags == '0 && en == '0));
endmodule

bind sram_parity_collector pc_checker #(.NREG(NREG)) chk_i (
  .clk     (clk),
  .por_n   (por_n),
  .rst_n   (rst_any_n),
  .avail   (avail_q),
  .kill_ev (kill_ev),
  .rd_ev   (rd_status_ev),
  .set_any (set_any),
  .err     (par_err_i),
  .flags   (flags),
  .en      (en),
  .irq     (irq_o)
);

// File: tb/sram_parity_collector_tb.sv
module sram_parity_collector_tb_top;
  localparam int NREG = 7;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic            warm_rst_n = 1'b1;
  logic [NREG-1:0] par_err = '0;
  logic            bus_valid = 1'b0;
  logic            bus_write = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [NREG-1:0] bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_parity_collector #(.NREG(NREG), .DW(DW)) dut_i (
    .clk         (clk),
    .por_n       (por_n),
    .warm_rst_n  (warm_rst_n),
    .par_err_i   (par_err),
    .bus_valid_i (bus_valid),
    .bus_write_i (bus_write),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  localparam logic [1:0] A_EN = 2'd0, A_ST = 2'd1, A_CT = 2'd2;

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [NREG-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  // Read with an optional coincident error pulse; rdata sampled mid-cycle.
  task automatic do_read(input logic [1:0] a, input logic [NREG-1:0] err,
                         output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; par_err = err;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0; par_err = '0;
  endtask

  task automatic pulse_err(input logic [NREG-1:0] m);
    @(negedge clk);
    par_err = m;
    @(negedge clk);
    par_err = '0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic do_warm();
    @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_por();
    check("R1 irq", {31'b0, irq}, 32'h0);
    do_read(A_EN, '0, d); check("R1 enable", d, 32'h0);
    do_read(A_ST, '0, d); check("R1 status", d, 32'h0);
    do_read(A_CT, '0, d); check("R1 available", d, 32'h1);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse_err(7'h05);
    repeat (3) @(negedge clk);
    do_read(A_ST, '0, d); check("R2/R11 sticky multi", d, 32'h05);
    do_read(A_ST, '0, d); check("R3 cleared by read", d, 32'h0);
    pulse_err(7'h40);
    do_read(A_ST, '0, d); check("R2 top region", d, 32'h40);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    do_write(A_EN, 7'h7F);
    do_read(A_EN, '0, d); check("R6 enable all", d, 32'h7F);
    do_write(A_EN, 7'h2A);
    do_read(A_EN, '0, d); check("R6 enable pattern", d, 32'h2A);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    do_write(A_EN, 7'h02);
    pulse_err(7'h01);
    check("R5 irq off for disabled region", {31'b0, irq}, 32'h0);
    pulse_err(7'h02);
    check("R5 irq on for enabled region", {31'b0, irq}, 32'h1);
    do_read(A_ST, '0, d); check("R3 status both", d, 32'h03);
    check("R5 irq drops after read", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse_err(7'h10);
    do_read(A_ST, 7'h08, d); check("R4 read returns old", d, 32'h10);
    do_read(A_ST, '0, d); check("R4 coincident kept", d, 32'h08);
  endtask

  task automatic t_warm();
    logic [31:0] d;
    do_write(A_EN, 7'h7F);
    pulse_err(7'h01);
    check("R5 irq before warm", {31'b0, irq}, 32'h1);
    do_warm();
    check("R10 irq after warm", {31'b0, irq}, 32'h0);
    do_read(A_EN, '0, d); check("R10 enable cleared", d, 32'h0);
    do_read(A_ST, '0, d); check("R10 status cleared", d, 32'h0);
    do_read(A_CT, '0, d); check("R10 available kept", d, 32'h1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_write(A_CT, 7'h00);
    do_read(A_CT, '0, d); check("R7 write zero no effect", d, 32'h1);
    do_write(A_EN, 7'h7F);
    pulse_err(7'h04);
    do_write(A_CT, 7'h01);
    do_read(A_CT, '0, d); check("R7 disabled", d, 32'h0);
    check("R9 irq gated", {31'b0, irq}, 32'h0);
    do_read(A_ST, '0, d); check("R9 old flag readable", d, 32'h04);
    pulse_err(7'h7F);
    do_read(A_ST, '0, d); check("R9 errors ignored", d, 32'h0);
    check("R9 irq stays low", {31'b0, irq}, 32'h0);
    do_write(A_CT, 7'h7F);
    do_write(A_CT, 7'h00);
    do_read(A_CT, '0, d); check("R8 no revive by write", d, 32'h0);
    do_warm();
    do_read(A_CT, '0, d); check("R8 no revive by warm", d, 32'h0);
    do_por();
    do_read(A_CT, '0, d); check("R8 revived by por", d, 32'h1);
    pulse_err(7'h20);
    do_read(A_ST, '0, d); check("R2 works after por", d, 32'h20);
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_enable_rw();
    t_irq();
    t_collide();
    t_warm();
    t_disable();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule